// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave Controller

This block is the serial front end and control logic of a small 1-kilobit memory. A master reaches it over four wires: select, serial clock, data in and data out. A system clock runs much faster than the serial clock and oversamples all three serial inputs. A new instruction starts with a 1 on data in. The block then collects a two-bit opcode, an address and, where the instruction needs it, write data. From these it runs word reads, word writes, word erases, erase-all and write-all against an internal register array.

The storage is always the same 1024 bits. A quasi-static organisation pin chooses how it is addressed: as 64 words of 16 bits, or as 128 bytes of 8 bits. Any change to storage starts a self-timed busy period that is counted in system clock cycles. A ready output shows this period, and it runs to the end even if select is dropped. A read puts out one leading zero before the data. Data out is enabled only while read bits are being shifted.

Top module: `mw_mem_slave`

## Requirements
- R1: While `cs` is low the serial logic stays idle and `dout_oe` is low. Dropping `cs` before an instruction is complete discards it, and memory is left unchanged.
- R2: While `cs` is high and no start bit has arrived, serial clock rises with `din` = 0 change nothing. The first rise with `din` = 1 is the start bit.
- R3: After the start bit, bits are taken MSB first on rising serial clock edges. The order is opcode (2 bits), then address (6 bits when `org` = 1, 7 bits when `org` = 0), then data where needed (16 bits when `org` = 1, 8 bits when `org` = 0).
- R4: Opcode encodings are 10 = read, 01 = write word, 11 = erase word, 00 = control. For control, the two most significant address bits select the action: 11 = enable modify, 00 = disable modify, 10 = erase-all, 01 = write-all (data follows).
- R5: Modify is disabled after reset. Write, erase, erase-all and write-all have no effect, and start no busy period, unless the last enable/disable instruction was enable.
- R6: For a read, `dout_oe` rises once the last address bit is taken, and `dout` first shows a dummy 0. Each following serial clock rise puts out the next data bit, MSB first. The rise after the last data bit releases `dout_oe`.
- R7: With `org` = 0, byte address A maps to word A>>1. A[0] = 1 selects that word's upper half and A[0] = 0 its lower half. Both organisations share the same storage.
- R8: A modify operation holds `ready` low for exactly WRITE_CYCLES system clock cycles, whatever `cs` does. `ready` is high after reset.
- R9: After an instruction has taken all its bits, further clock and data activity is ignored until `cs` goes low and then high again. While `ready` is low, start bits are ignored.
- R10: Storage resets to all ones. An erased word or byte reads as all ones.
- R11: Write-all stores its data in every word. In byte mode the byte is stored in both halves of every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Select; high selects the device |
| sclk | input | 1 | Serial clock from the master |
| din | input | 1 | Serial data in |
| org | input | 1 | 1 = 64x16 words, 0 = 128x8 bytes |
| dout | output | 1 | Serial read data |
| dout_oe | output | 1 | Output enable for `dout` (high only while read data is shifted) |
| ready | output | 1 | High when no self-timed operation is in progress |

## Verification
The assertions check several rules on every cycle: the exact length of each busy period, that read output stays off while busy, that the output enable is released after select drops, that a read always opens with a zero, and that a busy period can only begin while modify is enabled. The bench scenarios are the only way to show the rest: the instruction framing and opcode decoding, how bytes map onto words, that a cancelled instruction leaves memory untouched, that leading zeros and trailing clocks are ignored, and the stored contents after erase, write-all and erase-all. All of these are shown by reading data back over the serial port.

// File: rtl/mw_pkg.sv
package mw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
   } mw_state_t;

   typedef enum logic [1:0] {
      WK_NONE, WK_WORD, WK_ALL
   } mw_wkind_t;

   localparam logic [1:0] OP_CTL   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] SUB_DIS  = 2'b00;
   localparam logic [1:0] SUB_WALL = 2'b01;
   localparam logic [1:0] SUB_EALL = 2'b10;
   localparam logic [1:0] SUB_EN   = 2'b11;
endpackage

// File: rtl/mw_sync_edge.sv
module mw_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sclk_i,
   input  logic din_i,
   output logic cs_o,
   output logic din_o,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mw_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] cs_p, ck_p, dt_p;
   logic              ck_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_p    <= '0;
         ck_p    <= '0;
         dt_p    <= '0;
         ck_last <= 1'b0;
      end else begin
         cs_p    <= {cs_p[STAGES-2:0], cs_i};
         ck_p    <= {ck_p[STAGES-2:0], sclk_i};
         dt_p    <= {dt_p[STAGES-2:0], din_i};
         ck_last <= ck_p[STAGES-1];
      end
   end

   assign cs_o   = cs_p[STAGES-1];
   assign din_o  = dt_p[STAGES-1];
   assign rise_o = ck_p[STAGES-1] & ~ck_last;
endmodule

// File: rtl/mw_array.sv
module mw_array
   import mw_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int HW    = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mw_wkind_t         wr_kind,
   input  logic [AW-1:0]     wr_idx,
   input  logic              wr_half,
   input  logic              wr_upper,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_idx,
   output logic [WORD_W-1:0] rd_word
);
   logic [WORD_W-1:0] rows [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_row
      logic              hit;
      logic [WORD_W-1:0] row;

      assign hit = (wr_kind == WK_ALL) ||
                   ((wr_kind == WK_WORD) && (wr_idx == AW'(w)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row <= '1;
         end else if (hit) begin
            if (!wr_half)
               row <= wr_data;
            else if (wr_kind == WK_ALL)
               row <= {2{wr_data[HW-1:0]}};
            else if (wr_upper)
               row[WORD_W-1:HW] <= wr_data[HW-1:0];
            else
               row[HW-1:0] <= wr_data[HW-1:0];
         end
      end

      assign rows[w] = row;
   end

   assign rd_word = rows[rd_idx];
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
   parameter int CYCLES = 40,
   localparam int CW    = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left <= '0;
      else if (start)
         left <= CW'(CYCLES);
      else if (left != '0)
         left <= left - 1'b1;
   end

   assign busy = (left != '0);
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
   import mw_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int AW     = 6,
   localparam int HW    = WORD_W / 2,
   localparam int BAW   = AW + 1,
   localparam int MAXB  = (WORD_W > BAW) ? WORD_W : BAW,
   localparam int CW    = $clog2(MAXB + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              din_s,
   input  logic              rise,
   input  logic              org,
   input  logic              busy,
   input  logic [WORD_W-1:0] rd_word,
   output logic [AW-1:0]     rd_idx,
   output mw_wkind_t         wr_kind,
   output logic [AW-1:0]     wr_idx,
   output logic              wr_half,
   output logic              wr_upper,
   output logic [WORD_W-1:0] wr_data,
   output logic              dout,
   output logic              dout_oe,
   output logic              wen
);
   mw_state_t         st;
   logic [1:0]        op;
   logic [BAW-1:0]    addr;
   logic [WORD_W-1:0] data, sh;
   logic [CW-1:0]     cnt;

   logic [BAW-1:0]    addr_nx;
   logic [WORD_W-1:0] data_nx, rd_sel;
   logic [CW-1:0]     alen, dlen;
   logic [1:0]        sub_nx;
   logic [AW-1:0]     idx_nx, idx_q;
   logic              up_nx, up_q;

   always_comb begin
      addr_nx = {addr[BAW-2:0], din_s};
      data_nx = {data[WORD_W-2:0], din_s};
      alen    = org ? CW'(AW) : CW'(BAW);
      dlen    = org ? CW'(WORD_W) : CW'(HW);
      sub_nx  = org ? addr_nx[AW-1:AW-2] : addr_nx[BAW-1:BAW-2];
      idx_nx  = org ? addr_nx[AW-1:0] : addr_nx[BAW-1:1];
      up_nx   = addr_nx[0];
      idx_q   = org ? addr[AW-1:0] : addr[BAW-1:1];
      up_q    = addr[0];
      rd_idx  = idx_nx;
      if (org)
         rd_sel = rd_word;
      else
         rd_sel = {(up_nx ? rd_word[WORD_W-1:HW] : rd_word[HW-1:0]), {HW{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op       <= '0;
         addr     <= '0;
         data     <= '0;
         sh       <= '0;
         cnt      <= '0;
         dout     <= 1'b0;
         dout_oe  <= 1'b0;
         wen      <= 1'b0;
         wr_kind  <= WK_NONE;
         wr_idx   <= '0;
         wr_half  <= 1'b0;
         wr_upper <= 1'b0;
         wr_data  <= '0;
      end else begin
         wr_kind <= WK_NONE;
         if (!cs_s) begin
            st      <= ST_IDLE;
            dout    <= 1'b0;
            dout_oe <= 1'b0;
         end else if (rise) begin
            case (st)
               ST_IDLE: begin
                  if (din_s && !busy) begin
                     st   <= ST_OPC;
                     cnt  <= '0;
                     addr <= '0;
                     data <= '0;
                  end
               end
               ST_OPC: begin
                  op  <= {op[0], din_s};
                  cnt <= cnt + 1'b1;
                  if (cnt == CW'(1)) begin
                     st  <= ST_ADDR;
                     cnt <= '0;
                  end
               end
               ST_ADDR: begin
                  addr <= addr_nx;
                  cnt  <= cnt + 1'b1;
                  if (cnt == alen - 1'b1) begin
                     cnt <= '0;
                     st  <= ST_DONE;
                     case (op)
                        OP_READ: begin
                           st      <= ST_READ;
                           sh      <= rd_sel;
                           dout    <= 1'b0;
                           dout_oe <= 1'b1;
                        end
                        OP_WRITE: st <= ST_DATA;
                        OP_ERASE: begin
                           if (wen) begin
                              wr_kind  <= WK_WORD;
                              wr_idx   <= idx_nx;
                              wr_upper <= up_nx;
                              wr_half  <= !org;
                              wr_data  <= '1;
                           end
                        end
                        default: begin
                           case (sub_nx)
                              SUB_EN:   wen <= 1'b1;
                              SUB_DIS:  wen <= 1'b0;
                              SUB_WALL: st  <= ST_DATA;
                              default: begin
                                 if (wen) begin
                                    wr_kind <= WK_ALL;
                                    wr_half <= !org;
                                    wr_data <= '1;
                                 end
                              end
                           endcase
                        end
                     endcase
                  end
               end
               ST_DATA: begin
                  data <= data_nx;
                  cnt  <= cnt + 1'b1;
                  if (cnt == dlen - 1'b1) begin
                     st <= ST_DONE;
                     if (wen) begin
                        wr_kind  <= (op == OP_WRITE) ? WK_WORD : WK_ALL;
                        wr_idx   <= idx_q;
                        wr_upper <= up_q;
                        wr_half  <= !org;
                        wr_data  <= data_nx;
                     end
                  end
               end
               ST_READ: begin
                  if (cnt == dlen) begin
                     st      <= ST_DONE;
                     dout    <= 1'b0;
                     dout_oe <= 1'b0;
                  end else begin
                     dout <= sh[WORD_W-1];
                     sh   <= {sh[WORD_W-2:0], 1'b0};
                     cnt  <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/mw_mem_slave.sv
module mw_mem_slave
   import mw_pkg::*;
#(
   parameter int WORD_W       = 16,
   parameter int WORDS        = 64,
   parameter int WRITE_CYCLES = 40,
   parameter int SYNC_STAGES  = 2,
   localparam int AW          = $clog2(WORDS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sclk,
   input  logic din,
   input  logic org,
   output logic dout,
   output logic dout_oe,
   output logic ready
);
   generate
      if ((WORD_W < 4) || (WORD_W % 2 != 0)) begin : g_bad_width
         $error("mw_mem_slave: WORD_W must be even and at least 4");
      end
      if ((WORDS < 4) || ((1 << AW) != WORDS)) begin : g_bad_depth
         $error("mw_mem_slave: WORDS must be a power of two, at least 4");
      end
      if (WRITE_CYCLES < 2) begin : g_bad_cycles
         $error("mw_mem_slave: WRITE_CYCLES must be at least 2");
      end
   endgenerate

   logic              cs_s, din_s, rise, busy, wen;
   logic [WORD_W-1:0] rd_word, wr_data;
   logic [AW-1:0]     rd_idx, wr_idx;
   logic              wr_half, wr_upper;
   mw_wkind_t         wr_kind;

   mw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .din_i(din),
      .cs_o(cs_s), .din_o(din_s), .rise_o(rise)
   );

   mw_ctrl #(.WORD_W(WORD_W), .AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .din_s(din_s), .rise(rise),
      .org(org), .busy(busy), .rd_word(rd_word), .rd_idx(rd_idx),
      .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_half(wr_half),
      .wr_upper(wr_upper), .wr_data(wr_data), .dout(dout),
      .dout_oe(dout_oe), .wen(wen)
   );

   mw_array #(.WORD_W(WORD_W), .DEPTH(WORDS)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_kind(wr_kind), .wr_idx(wr_idx),
      .wr_half(wr_half), .wr_upper(wr_upper), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_word(rd_word)
   );

   mw_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(wr_kind != WK_NONE), .busy(busy)
   );

   assign ready = !busy;
endmodule

// File: rtl/mw_mem_slave_chk.sv
module mw_mem_slave_chk #(
   parameter int WRITE_CYCLES = 40,
   localparam int LW          = $clog2(WRITE_CYCLES + 1) + 1
) (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic dout,
   input logic dout_oe,
   input logic ready,
   input logic wen
);
   logic [LW-1:0] lowcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lowcnt <= '0;
      else if (ready)
         lowcnt <= '0;
      else
         lowcnt <= lowcnt + 1'b1;
   end

   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && (lowcnt < LW'(WRITE_CYCLES - 1))) |=> !ready); // R8
   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && (lowcnt == LW'(WRITE_CYCLES - 1))) |=> ready); // R8
   AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !dout_oe); // R1
   AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_oe) |-> !dout); // R6
   AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !dout_oe); // R9
   AST_GUARDED_MODIFY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> wen); // R5
endmodule

bind mw_mem_slave mw_mem_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .dout(dout),
   .dout_oe(dout_oe), .ready(ready), .wen(wen)
);

// File: tb/sim_mw_mem_slave.sv
`timescale 1ns/1ps
module sim_mw_mem_slave;
   localparam int WC = 40;

   typedef struct {
      logic [15:0] v;
      int          w;
      string       tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sclk = 1'b0, din = 1'b0, org = 1'b1;
   logic dout, dout_oe, ready;

   int checks = 0, failures = 0;
   int run = 0, last_run = 0;
   bit done = 0;
   item_t q[$];

   always #5 clk = ~clk;

   mw_mem_slave #(.WRITE_CYCLES(WC)) u0 (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
      .org(org), .dout(dout), .dout_oe(dout_oe), .ready(ready)
   );

   always @(posedge clk) begin
      if (!ready) run <= run + 1;
      else begin
         if (run != 0) last_run <= run;
         run <= 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic b);
      din = b;
      tick(10); sclk = 1'b1;
      tick(10); sclk = 1'b0;
   endtask

   task automatic send(input logic [15:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) pulse(v[i]);
   endtask

   function automatic int alen();
      return org ? 6 : 7;
   endfunction

   function automatic int dlen();
      return org ? 16 : 8;
   endfunction

   task automatic cs_on();  cs = 1'b1; tick(5); endtask
   task automatic cs_off(); cs = 1'b0; din = 1'b0; tick(8); endtask

   task automatic instr(input logic [1:0] op, input logic [15:0] a);
      pulse(1'b1);
      send({14'd0, op}, 2);
      send(a, alen());
   endtask

   task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
      item_t it;
      it.v = exp; it.w = dlen(); it.tag = tag;
      q.push_back(it);
      cs_on();
      instr(2'b10, a);
      repeat (dlen()) pulse(1'b0);
      cs_off();
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      cs_on();
      instr(2'b01, a);
      send(d, dlen());
      cs_off();
   endtask

   task automatic ctl(input logic [1:0] sub);
      cs_on();
      instr(2'b00, 16'(sub) << (alen() - 2));
      cs_off();
   endtask

   task automatic wait_ready();
      int n = 0;
      while (!ready && n < 1000) begin tick(1); n++; end
   endtask

   // monitor: pop the expected item when the design starts shifting
   initial begin
      forever begin
         item_t it;
         logic [15:0] got;
         @(posedge dout_oe);
         if (q.size() == 0) begin
            chk(1'b0, "R6 unexpected read output", 1, 0);
            continue;
         end
         it = q.pop_front();
         got = '0;
         @(negedge sclk);
         chk(dout == 1'b0 && dout_oe, "R6 dummy zero", int'(dout), 0);
         for (int i = 0; i < it.w; i++) begin
            @(negedge sclk);
            got = {got[14:0], dout};
         end
         chk(got == it.v, it.tag, int'(got), int'(it.v));
      end
   end

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         report();
         $finish;
      end
   end

   initial begin
      tick(4); rst_n = 1'b1; tick(4);
      chk(ready == 1'b1, "R8 ready after reset", int'(ready), 1);
      chk(dout_oe == 1'b0, "R1 oe low after reset", int'(dout_oe), 0);

      rd(5, 16'hFFFF, "R10 reset content");

      wr(3, 16'hA5C3);
      chk(ready == 1'b1, "R5 write before enable starts no busy", int'(ready), 1);
      rd(3, 16'hFFFF, "R5 write before enable ignored");

      ctl(2'b11);
      wr(3, 16'hA5C3);
      chk(ready == 1'b0, "R8 busy continues with cs low", int'(ready), 0);
      wait_ready(); tick(2);
      chk(last_run == WC, "R8 busy length", last_run, WC);
      rd(3, 16'hA5C3, "R3 word read back");

      // R2: idle clocks with din low before start bit
      begin
         item_t it;
         it.v = 16'hA5C3; it.w = 16; it.tag = "R2 leading zeros ignored";
         q.push_back(it);
         cs_on();
         repeat (5) pulse(1'b0);
         instr(2'b10, 3);
         repeat (16) pulse(1'b0);
         cs_off();
      end

      // R1: abort a write half way
      cs_on(); instr(2'b01, 3); send(16'h00FF, 8); cs_off();
      chk(ready == 1'b1, "R1 aborted write starts no busy", int'(ready), 1);
      rd(3, 16'hA5C3, "R1 aborted write leaves data");

      // R9: start bit while busy ignored
      wr(10, 16'h0F3C);
      cs_on();
      chk(ready == 1'b0, "R9 still busy", int'(ready), 0);
      pulse(1'b1);
      chk(dout_oe == 1'b0, "R9 start ignored while busy", int'(dout_oe), 0);
      cs_off();
      wait_ready();
      rd(10, 16'h0F3C, "R3 second word");

      // R9/R6: extra clocks after a complete read
      begin
         item_t it;
         it.v = 16'hA5C3; it.w = 16; it.tag = "R6 read before extra clocks";
         q.push_back(it);
         cs_on();
         instr(2'b10, 3);
         repeat (16) pulse(1'b0);
         pulse(1'b1);
         chk(dout_oe == 1'b0, "R6 oe released after last bit", int'(dout_oe), 0);
         pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b1);
         repeat (8) pulse(1'b1);
         chk(dout_oe == 1'b0, "R9 trailing clocks ignored", int'(dout_oe), 0);
         chk(ready == 1'b1, "R9 trailing clocks start nothing", int'(ready), 1);
         cs_off();
      end

      // R4: erase one word
      cs_on(); instr(2'b11, 3); cs_off();
      wait_ready();
      rd(3, 16'hFFFF, "R4 erase word");
      rd(10, 16'h0F3C, "R4 erase leaves neighbour");

      // R7: byte organisation
      org = 1'b0; tick(4);
      rd(21, 16'h000F, "R7 upper byte");
      rd(20, 16'h003C, "R7 lower byte");
      wr(8, 16'h005A);
      wait_ready();
      org = 1'b1; tick(4);
      rd(4, 16'hFF5A, "R7 byte write lands in lower half");

      // R11: write-all in both organisations
      cs_on(); instr(2'b00, 16'h0010); send(16'h1234, 16); cs_off();
      wait_ready();
      rd(0, 16'h1234, "R11 write-all word 0");
      rd(63, 16'h1234, "R11 write-all last word");
      org = 1'b0; tick(4);
      cs_on(); instr(2'b00, 16'h0020); send(16'h0077, 8); cs_off();
      wait_ready();
      org = 1'b1; tick(4);
      rd(9, 16'h7777, "R11 byte write-all both halves");

      // R4/R10: erase-all
      ctl(2'b10);
      wait_ready();
      rd(9, 16'hFFFF, "R10 erase-all reads ones");

      // R5: disable then write
      ctl(2'b00);
      wr(2, 16'h1111);
      chk(ready == 1'b1, "R5 write after disable starts no busy", int'(ready), 1);
      rd(2, 16'hFFFF, "R5 write after disable ignored");

      tick(20);
      chk(q.size() == 0, "R6 all reads produced output", q.size(), 0);
      done = 1;
      report();
      $finish;
   end
endmodule